// File: doc/BRIEF.md
# Signed Multiply-Accumulate with Redundant Feedback

This block multiplies two signed 8-bit operands and adds the product to a running 24-bit total. The loop never resolves a full-width carry. The multiplier is recoded into radix-4 Booth digits, which gives four partial-product rows. Those rows, a row of negate bits and the stored total all enter one carry-save tree.

The total is stored in two parts. The upper 16 bits stay redundant, as separate sum and carry vectors. The lower 8 bits are resolved every cycle by a chain of 2-bit carry-lookahead blocks and are kept as plain binary. The carry out of that low section is held for one cycle and enters the tree at bit 8 on the next update.

A 16-bit adder forms the binary result only when a read is requested. The result lands in an output register one cycle after the request. Typical use is filter taps or dot products: clear, stream operand pairs with `acc_en`, then strobe `rd_req`.

Top module: `hcs_mac`

## Requirements
- R1: After reset, `acc_out` is 0 and `out_valid` is 0.
- R2: An edge with `acc_en` high and `acc_clr` low adds the two's-complement product `a_in * b_in` to the accumulated value, modulo 2^24.
- R3: An edge with `rd_req` high loads into `acc_out` the accumulated value as it stood before that edge, excluding any product taken at the same edge. `out_valid` is then high for the following cycle only.
- R4: While `rd_req` is low, `acc_out` keeps its value and `out_valid` reads 0 after the edge.
- R5: An edge with `acc_clr` high and `acc_en` low sets the accumulated value to 0. With both high, the value becomes that edge's product alone.
- R6: An edge with `acc_en` and `acc_clr` both low leaves the accumulated value unchanged, whatever `a_in` and `b_in` carry.
- R7: Every one of the 65536 signed operand pairs, including -128 on either side, yields its exact product.
- R8: 256 products of (-128)*(-128) total exactly 4194304 without overflow. Continuing to 1024 such products wraps the total to 0 (modulo 2^24).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 8 | Signed multiplicand |
| b_in | input | 8 | Signed multiplier, Booth recoded |
| acc_en | input | 1 | Take the product of this cycle |
| acc_clr | input | 1 | Drop the stored total |
| rd_req | input | 1 | Request the binary total |
| acc_out | output | 24 | Resolved total, two's complement |
| out_valid | output | 1 | `acc_out` was loaded at the last edge |

## Verification
On every cycle, the checker compares each read result against a behavioural running sum kept beside the design. It also checks the one-cycle `out_valid` pulse, the holding of `acc_out` between reads, the zeroed state after a clear, and the frozen redundant state during idle cycles.

Exhaustive coverage of the operand space is shown only by the bench's scenarios. The same holds for the exact no-overflow margin and the wrap of the 24-bit total, and for reads that coincide with an accumulate or a clear.

// File: rtl/hcs_mac.sv
module hcs_mac #(
  parameter int W   = 8,
  parameter int ACC = 24,
  parameter int LO  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  input  logic           acc_en,
  input  logic           acc_clr,
  input  logic           rd_req,
  output logic [ACC-1:0] acc_out,
  output logic           out_valid
);
  localparam int NR = W / 2;
  localparam int HI = ACC - LO;
  localparam int NB = LO / 2;

  logic [LO-1:0] lo_q;
  logic [HI-1:0] s_hi_q, c_hi_q;
  logic          cy_q;

  function automatic logic [2*ACC-1:0] csa(input logic [ACC-1:0] p, q, r);
    logic [ACC-1:0] s, k;
    s = p ^ q ^ r;
    k = ((p & q) | (p & r) | (q & r)) << 1;
    return {k, s};
  endfunction

  wire [ACC-1:0] a_ext = {{(ACC-W){a_in[W-1]}}, a_in};
  wire [W:0]     b_pad = {b_in, 1'b0};

  logic [ACC-1:0] pp [NR];
  logic [NR-1:0]  neg_b;

  for (genvar i = 0; i < NR; i++) begin : g_booth
    wire [2:0]     trip = b_pad[2*i+2 : 2*i];
    wire           one  = trip[1] ^ trip[0];
    wire           two  = (trip == 3'b011) || (trip == 3'b100);
    wire [ACC-1:0] mag  = one ? a_ext : (two ? (a_ext << 1) : '0);
    assign neg_b[i] = trip[2] && (trip != 3'b111);
    assign pp[i]    = (neg_b[i] ? ~mag : mag) << (2*i);
  end

  wire keep = ~acc_clr;
  wire [ACC-1:0] fb_s = keep ? {s_hi_q, lo_q} : '0;
  wire [ACC-1:0] fb_c = keep ? {c_hi_q, {LO{1'b0}}} : '0;

  logic [ACC-1:0] bitrow;
  always_comb begin
    bitrow = '0;
    for (int i = 0; i < NR; i++) bitrow[2*i] = neg_b[i];
    bitrow[LO] = keep & cy_q;
  end

  logic [ACC-1:0] s1, k1, s2, k2, s3, k3, s4, k4, sf, kf;
  always_comb begin
    {k1, s1} = csa(pp[0], pp[1], pp[2]);
    {k2, s2} = csa(pp[3], bitrow, fb_s);
    {k3, s3} = csa(s1, k1, s2);
    {k4, s4} = csa(s3, k3, k2);
    {kf, sf} = csa(s4, k4, fb_c);
  end

  logic [NB:0]   cc;
  logic [LO-1:0] lo_nx;
  assign cc[0] = 1'b0;
  for (genvar b = 0; b < NB; b++) begin : g_cla2
    wire [1:0] g = sf[2*b+1 : 2*b] & kf[2*b+1 : 2*b];
    wire [1:0] p = sf[2*b+1 : 2*b] ^ kf[2*b+1 : 2*b];
    wire       c1 = g[0] | (p[0] & cc[b]);
    assign cc[b+1] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cc[b]);
    assign lo_nx[2*b+1 : 2*b] = p ^ {c1, cc[b]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      s_hi_q <= '0;
      c_hi_q <= '0;
      cy_q   <= 1'b0;
    end else if (acc_en) begin
      lo_q   <= lo_nx;
      s_hi_q <= sf[ACC-1:LO];
      c_hi_q <= kf[ACC-1:LO];
      cy_q   <= cc[NB];
    end else if (acc_clr) begin
      lo_q   <= '0;
      s_hi_q <= '0;
      c_hi_q <= '0;
      cy_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= rd_req;
      if (rd_req) acc_out <= {s_hi_q + c_hi_q + HI'(cy_q), lo_q};
    end
  end
endmodule

// File: rtl/hcs_mac_chk.sv
module hcs_mac_chk #(
  parameter int W   = 8,
  parameter int ACC = 24,
  parameter int LO  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     a_in,
  input logic [W-1:0]     b_in,
  input logic             acc_en,
  input logic             acc_clr,
  input logic             rd_req,
  input logic [ACC-1:0]   acc_out,
  input logic             out_valid,
  input logic [LO-1:0]    lo_q,
  input logic [ACC-LO-1:0] s_hi_q,
  input logic [ACC-LO-1:0] c_hi_q,
  input logic             cy_q
);
  logic signed [2*W-1:0] prod;
  logic [ACC-1:0] ref_q;
  assign prod = $signed(a_in) * $signed(b_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else if (acc_en) ref_q <= (acc_clr ? '0 : ref_q) + {{(ACC-2*W){prod[2*W-1]}}, prod};
    else if (acc_clr) ref_q <= '0;
  end

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> out_valid);
  // R4
  no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_req |=> !out_valid);
  // R3
  rd_value_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> acc_out == $past(ref_q));
  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_req |=> $stable(acc_out));
  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clr && !acc_en) |=> (lo_q == '0 && s_hi_q == '0 && c_hi_q == '0 && !cy_q));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !acc_clr) |=> $stable({s_hi_q, c_hi_q, lo_q, cy_q}));
endmodule

bind hcs_mac hcs_mac_chk #(.W(W), .ACC(ACC), .LO(LO)) u_chk (.*);

// File: tb/hcs_mac_tb.sv
module hcs_mac_tb;
  logic clk = 0, rst_n = 0;
  logic [7:0] a_in = 0, b_in = 0;
  logic acc_en = 0, acc_clr = 0, rd_req = 0;
  logic [23:0] acc_out;
  logic out_valid;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  hcs_mac u_dut (.clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .acc_en(acc_en),
                 .acc_clr(acc_clr), .rd_req(rd_req), .acc_out(acc_out), .out_valid(out_valid));

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic c, input logic r, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    acc_en = v; acc_clr = c; rd_req = r; a_in = a; b_in = b;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [23:0] mul(input logic [7:0] a, input logic [7:0] b);
    int p;
    p = int'($signed(a)) * int'($signed(b));
    return 24'(p);
  endfunction

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] ref_v, prev, held;
    logic [31:0] lf;
    logic v, c, r;
    logic [7:0] a, b;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(acc_out == 0 && out_valid == 0, "R1", acc_out, 0);
    @(negedge clk); rst_n = 1;

    // R7: each pair loaded by clear+accumulate, read back one edge later
    prev = 0;
    for (int xi = 0; xi < 256; xi++) begin
      for (int yi = 0; yi < 256; yi++) begin
        cyc(1, 1, 1, 8'(xi), 8'(yi));
        if (xi != 0 || yi != 0) chk(acc_out == prev, "R7", acc_out, prev);
        prev = mul(8'(xi), 8'(yi));
      end
    end
    cyc(0, 0, 1, 0, 0);
    chk(acc_out == prev, "R7", acc_out, prev);
    chk(out_valid == 1, "R3", 24'(out_valid), 1);

    // R5: clear alone zeroes
    cyc(1, 0, 0, 8'd50, 8'd3);
    cyc(0, 1, 0, 8'd9, 8'd9);
    cyc(0, 0, 1, 8'd9, 8'd9);
    chk(acc_out == 0, "R5", acc_out, 0);

    // R2 R3 R4: pseudo-random stream, running reference
    ref_v = 0; lf = 32'h1234_5678; held = acc_out;
    for (int n = 0; n < 3000; n++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      v = lf[0] | lf[1]; r = (lf[4:2] == 3'd0); c = (lf[15:8] == 8'd7);
      a = lf[23:16]; b = lf[31:24];
      cyc(v, c, r, a, b);
      if (r) begin
        chk(acc_out == ref_v, "R3", acc_out, ref_v);
        chk(out_valid == 1, "R3", 24'(out_valid), 1);
        held = acc_out;
      end else begin
        chk(acc_out == held && out_valid == 0, "R4", acc_out, held);
      end
      if (v) ref_v = (c ? 24'd0 : ref_v) + mul(a, b);
      else if (c) ref_v = 0;
    end
    cyc(0, 0, 1, 0, 0);
    chk(acc_out == ref_v, "R2", acc_out, ref_v);
    cyc(0, 0, 0, 0, 0);
    chk(out_valid == 0, "R3", 24'(out_valid), 0);

    // R6: idle cycles with changing operands leave the total alone
    for (int n = 0; n < 8; n++) cyc(0, 0, 0, 8'(n * 37), 8'(n * 91));
    cyc(0, 0, 1, 0, 0);
    chk(acc_out == ref_v, "R6", acc_out, ref_v);

    // R8: extreme products, margin and wrap
    cyc(1, 1, 0, 8'h80, 8'h80);
    for (int n = 1; n < 256; n++) cyc(1, 0, 0, 8'h80, 8'h80);
    cyc(0, 0, 1, 0, 0);
    chk(acc_out == 24'd4194304, "R8", acc_out, 24'd4194304);
    for (int n = 256; n < 1024; n++) cyc(1, 0, 0, 8'h80, 8'h80);
    cyc(1, 0, 1, 8'h80, 8'h80);
    chk(acc_out == 0, "R8", acc_out, 0);
    cyc(0, 0, 1, 0, 0);
    chk(acc_out == 24'd16384, "R8", acc_out, 24'd16384);
    // R5: clear with accumulate loads the product alone
    cyc(1, 1, 0, 8'h7F, 8'h80);
    cyc(0, 0, 1, 0, 0);
    chk(acc_out == mul(8'h7F, 8'h80), "R5", acc_out, mul(8'h7F, 8'h80));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule